// File: doc/BRIEF.md
# Guarded Watchdog Configuration Register

This block keeps the byte-wide configuration register of a supervisory circuit. The register holds a two-bit watchdog period selection, which is kept in storage that survives power cycles, and two volatile enable latches that must be set in order before that selection may change. A serial-bus slave in front of this block passes each received data byte in on a strobe and signals the stop condition on a second strobe. This block answers each data byte with accept or refuse, which the slave turns into the acknowledge bit. It applies an accepted byte only when the stop arrives.

Changing the period takes three separate transfers. The first sets the write enable latch. The second sets the register write enable latch. The third carries the new period and starts a timed nonvolatile cycle, which clears the register write enable. A write-protect input refuses every write. The non-volatile bits are modelled as flops that only the chip reset initialises (to the factory value 11, watchdog off). A separate power-cycle input clears only the volatile latches.

Top module: `wdcfg_guard`

## Requirements
- R1: After `rst_n` is low at a clock edge, `cfg_q` reads 0x60 (period bits 11, both latches 0), `nv_busy` is 0, and `data_ack` is 0 while no byte is strobed.
- R2: A `pwr_cyc` pulse clears both latches (bits 2 and 1) and any pending byte. The period bits at 6:5 keep their value.
- R3: While the write enable latch (bit 1) is 0, every byte other than 0x00 and 0x02 is refused.
- R4: Byte 0x02, accepted and then followed by a stop, sets bit 1. Byte 0x00, followed by a stop, clears bit 1. Neither byte raises `nv_busy`.
- R5: With bit 1 set, byte 0x06 followed by a stop sets bit 2 and keeps bit 1, with no busy period. Bit 2 only rises at the edge that takes a stop.
- R6: With bits 1 and 2 set, a byte of the form 0xy00010 followed by a stop writes xy to bits 6:5 and clears bit 2. It then holds `nv_busy` high for exactly NV_CYCLES cycles. Bits 6:5 change at no other time except chip reset.
- R7: With bit 2 set, a byte of the form 0xy00110 followed by a stop leaves bit 2 set and bits 6:5 unchanged. With bit 2 clear, such a byte with xy not 00 is refused.
- R8: While `wp` is high, every byte is refused. The attempt clears bit 2 and changes neither bit 1 nor bits 6:5.
- R9: While `nv_busy` is high, every byte is refused and the register does not change.
- R10: A byte that matches none of the patterns above is refused and changes nothing. Bits 7, 4, 3 and 0 always read 0.
- R11: A second byte that arrives before the stop is refused and cancels the first, so the following stop changes nothing.
- R12: A stop with no accepted byte pending changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low chip reset; initialises all state, including the period bits |
| pwr_cyc | input | 1 | Synchronous power-cycle pulse; clears the volatile latches only |
| wr_stb | input | 1 | One-cycle strobe: a data byte is on `wr_byte` |
| wr_byte | input | 8 | Data byte written to the register |
| stop_stb | input | 1 | One-cycle strobe: stop condition seen, apply the pending byte |
| wp | input | 1 | Write protect, high refuses all writes |
| cfg_q | output | 8 | Current register value |
| data_ack | output | 1 | Same-cycle accept (1) or refuse (0) for the strobed byte |
| nv_busy | output | 1 | Nonvolatile write cycle in progress |

## Verification
The hardest states to reach are the ones that need the full unlock ladder in place before the corner case can be tried. Examples are a keep-latch pattern with a non-zero period field, a protected write that drops bit 2 while bit 1 survives, and a byte strobed in the first cycle of the busy window. The vector table walks the ladder several times so that each of these states comes up in order. Directed tests follow for the cancelled second byte, the exact busy length, and the power-cycle and reset cases, which need the period bits to hold a non-factory value first.

// File: rtl/wdcfg_pkg.sv
// Shared definitions for the guarded configuration register.
// Assumes: bit positions below are fixed by the write patterns the host uses.
package wdcfg_pkg;

    localparam int unsigned CFG_W    = 8;
    localparam int unsigned WD_LSB   = 5;  // period field occupies bits 6:5
    localparam int unsigned WD_W     = 2;
    localparam int unsigned RWEL_BIT = 2;
    localparam int unsigned WEL_BIT  = 1;
    localparam logic [WD_W-1:0] WD_FACTORY = 2'b11;

    // Low five bits of the two accepted byte families (bit 7 must be 0).
    localparam logic [4:0] TAIL_COMMIT = 5'b00010;
    localparam logic [4:0] TAIL_ARM    = 5'b00110;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_SET_WEL,
        OP_CLR_WEL,
        OP_SET_RWEL,
        OP_NV_WRITE
    } op_e;

    typedef struct packed {
        op_e             op;
        logic [WD_W-1:0] wd;
    } cmd_t;

endpackage

// File: rtl/wdcfg_decode.sv
// Byte classifier: decides in the strobe cycle whether a data byte is
// accepted and which operation the following stop will perform.
// Assumes: busy, protect and pending status are current-cycle values.
module wdcfg_decode
    import wdcfg_pkg::*;
(
    input  logic             wr_stb,
    input  logic [CFG_W-1:0] wr_byte,
    input  logic             wel,
    input  logic             rwel,
    input  logic             busy,
    input  logic             wp,
    input  logic             pend,
    output logic             accept,
    output logic             wp_hit,
    output cmd_t             cmd
);

    logic             top_zero;
    logic             is_commit;
    logic             is_arm;
    logic [WD_W-1:0]  field;

    assign top_zero  = ~wr_byte[CFG_W-1];
    assign is_commit = top_zero && (wr_byte[4:0] == TAIL_COMMIT);
    assign is_arm    = top_zero && (wr_byte[4:0] == TAIL_ARM);
    assign field     = wr_byte[WD_LSB +: WD_W];
    assign wp_hit    = wr_stb && wp;

    // Purpose: ordered acceptance rules, earliest match wins.
    always_comb begin
        accept = 1'b0;
        cmd    = '{op: OP_NONE, wd: field};
        if (!wr_stb || busy || wp || pend) begin
            accept = 1'b0;
        end else if (wr_byte == '0) begin
            accept = 1'b1;
            cmd.op = OP_CLR_WEL;
        end else if (wr_byte == 8'h02 && !(wel && rwel)) begin
            accept = 1'b1;
            cmd.op = OP_SET_WEL;
        end else if (!wel) begin
            accept = 1'b0;
        end else if (is_commit && rwel) begin
            accept = 1'b1;
            cmd.op = OP_NV_WRITE;
        end else if (is_arm && (field == '0 || rwel)) begin
            accept = 1'b1;
            cmd.op = OP_SET_RWEL;
        end
    end

endmodule

// File: rtl/wdcfg_state.sv
// Register state: volatile latches, the persistent period bits and the
// byte held between its strobe and the stop that applies it.
// Assumes: rst_n is the one-time chip reset; pwr_cyc models a supply cycle.
module wdcfg_state
    import wdcfg_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pwr_cyc,
    input  logic            wr_stb,
    input  logic            stop_stb,
    input  logic            accept,
    input  logic            wp_hit,
    input  cmd_t            cmd,
    output logic            wel,
    output logic            rwel,
    output logic [WD_W-1:0] wd,
    output logic            pend,
    output logic            nv_start
);

    cmd_t pend_cmd;

    assign nv_start = stop_stb && pend && !pwr_cyc && (pend_cmd.op == OP_NV_WRITE);

    // Purpose: persistent period bits, touched only by chip reset or a commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wd <= WD_FACTORY;
        end else if (nv_start) begin
            wd <= pend_cmd.wd;
        end
    end

    // Purpose: volatile latches and the pending byte.
    always_ff @(posedge clk) begin
        if (!rst_n || pwr_cyc) begin
            wel      <= 1'b0;
            rwel     <= 1'b0;
            pend     <= 1'b0;
            pend_cmd <= '{op: OP_NONE, wd: '0};
        end else if (stop_stb) begin
            pend <= 1'b0;
            if (pend) begin
                case (pend_cmd.op)
                    OP_SET_WEL:  wel <= 1'b1;
                    OP_CLR_WEL:  wel <= 1'b0;
                    OP_SET_RWEL: begin
                        wel  <= 1'b1;
                        rwel <= 1'b1;
                    end
                    OP_NV_WRITE: rwel <= 1'b0;
                    default:     ;
                endcase
            end
        end else if (wr_stb) begin
            pend     <= accept;
            pend_cmd <= cmd;
            if (wp_hit) begin
                rwel <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/wdcfg_nvtimer.sv
// Busy window for the nonvolatile cycle: high for NV_CYCLES clocks after
// the edge that starts a commit.
// Assumes: a new start cannot arrive while busy (writes are refused then).
module wdcfg_nvtimer #(
    parameter int unsigned NV_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);

    localparam int unsigned CNT_W = $clog2(NV_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(NV_CYCLES);

    logic [CNT_W-1:0] remain;

    // Purpose: load on start, count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (start) begin
            remain <= CNT_LOAD;
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign busy = (remain != '0);

endmodule

// File: rtl/wdcfg_guard.sv
// Top of the guarded configuration register: classifies bytes, holds the
// state and times the nonvolatile cycle.
// Assumes: wr_stb and stop_stb are one-cycle pulses that never coincide;
// if they do, the stop is taken and the byte is ignored.
module wdcfg_guard
    import wdcfg_pkg::*;
#(
    parameter int unsigned NV_CYCLES = 1000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_cyc,
    input  logic       wr_stb,
    input  logic [7:0] wr_byte,
    input  logic       stop_stb,
    input  logic       wp,
    output logic [7:0] cfg_q,
    output logic       data_ack,
    output logic       nv_busy
);

    logic            wel;
    logic            rwel;
    logic [WD_W-1:0] wd;
    logic            pend;
    logic            nv_start;
    logic            accept;
    logic            wp_hit;
    logic            byte_stb;
    cmd_t            cmd;

    assign byte_stb = wr_stb && !stop_stb && !pwr_cyc;

    wdcfg_decode u_decode (
        .wr_stb  (byte_stb),
        .wr_byte (wr_byte),
        .wel     (wel),
        .rwel    (rwel),
        .busy    (nv_busy),
        .wp      (wp),
        .pend    (pend),
        .accept  (accept),
        .wp_hit  (wp_hit),
        .cmd     (cmd)
    );

    wdcfg_state u_state (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwr_cyc  (pwr_cyc),
        .wr_stb   (byte_stb),
        .stop_stb (stop_stb),
        .accept   (accept),
        .wp_hit   (wp_hit),
        .cmd      (cmd),
        .wel      (wel),
        .rwel     (rwel),
        .wd       (wd),
        .pend     (pend),
        .nv_start (nv_start)
    );

    wdcfg_nvtimer #(.NV_CYCLES(NV_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (nv_start),
        .busy  (nv_busy)
    );

    // Purpose: assemble the readable register; unused bits read zero.
    always_comb begin
        cfg_q                    = '0;
        cfg_q[WD_LSB +: WD_W]    = wd;
        cfg_q[RWEL_BIT]          = rwel;
        cfg_q[WEL_BIT]           = wel;
    end

    assign data_ack = accept;

endmodule

// File: rtl/wdcfg_guard_chk.sv
// Property checker for wdcfg_guard, attached with bind below.
// Assumes: observes ports only.
module wdcfg_guard_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       pwr_cyc,
    input logic       wr_stb,
    input logic [7:0] wr_byte,
    input logic       stop_stb,
    input logic       wp,
    input logic [7:0] cfg_q,
    input logic       data_ack,
    input logic       nv_busy
);

    AST_BUSY_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
        nv_busy && wr_stb |-> !data_ack);  // R9

    AST_WP_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
        wp && wr_stb |-> !data_ack);  // R8

    AST_WP_DROPS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        wp && wr_stb && !stop_stb && !pwr_cyc |=> !cfg_q[2]);  // R8

    AST_NOWEL_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb && !cfg_q[1] && wr_byte != 8'h00 && wr_byte != 8'h02 |-> !data_ack);  // R3

    AST_PERIOD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !stop_stb |=> $stable(cfg_q[6:5]));  // R6

    AST_BUSY_ONLY_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nv_busy) |-> $past(stop_stb));  // R6

    AST_ARM_ONLY_AT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_q[2]) |-> $past(stop_stb));  // R5

    AST_PWR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_cyc |=> cfg_q[2:1] == 2'b00);  // R2

    // Purpose: reserved bits never read as one.
    always @(posedge clk) begin
        if (rst_n) begin
            AST_RSVD_ZERO: assert (cfg_q[7] == 1'b0 && cfg_q[4:3] == 2'b00 && cfg_q[0] == 1'b0);  // R10
        end
    end

endmodule

bind wdcfg_guard wdcfg_guard_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwr_cyc  (pwr_cyc),
    .wr_stb   (wr_stb),
    .wr_byte  (wr_byte),
    .stop_stb (stop_stb),
    .wp       (wp),
    .cfg_q    (cfg_q),
    .data_ack (data_ack),
    .nv_busy  (nv_busy)
);

// File: tb/wdcfg_guard_bench.sv
module wdcfg_guard_bench;

    localparam int unsigned NVC = 12;
    localparam int NV = 23;

    // Row: {kind(0 byte, 1 stop), wp, byte, expected ack, expected cfg after edge}
    localparam logic [19:0] VEC [NV] = '{
        {2'd0, 1'b0, 8'h06, 1'b0, 8'h60},  // R3 no WEL yet
        {2'd0, 1'b0, 8'h02, 1'b1, 8'h60},  // R4
        {2'd1, 1'b0, 8'h00, 1'b0, 8'h62},  // R4 WEL set
        {2'd0, 1'b0, 8'h06, 1'b1, 8'h62},  // R5
        {2'd1, 1'b0, 8'h00, 1'b0, 8'h66},  // R5 RWEL set
        {2'd0, 1'b0, 8'h55, 1'b0, 8'h66},  // R10 unmatched
        {2'd0, 1'b0, 8'h22, 1'b1, 8'h66},  // R6 period 01
        {2'd1, 1'b0, 8'h00, 1'b0, 8'h22},  // R6
        {2'd0, 1'b0, 8'h06, 1'b1, 8'h22},
        {2'd1, 1'b0, 8'h00, 1'b0, 8'h26},
        {2'd0, 1'b0, 8'h02, 1'b1, 8'h26},  // R6 02 commits 00
        {2'd1, 1'b0, 8'h00, 1'b0, 8'h02},
        {2'd0, 1'b0, 8'h06, 1'b1, 8'h02},
        {2'd1, 1'b0, 8'h00, 1'b0, 8'h06},
        {2'd0, 1'b0, 8'h46, 1'b1, 8'h06},  // R7 arm form, xy=10
        {2'd1, 1'b0, 8'h00, 1'b0, 8'h06},  // R7 unchanged
        {2'd0, 1'b1, 8'h06, 1'b0, 8'h02},  // R8 drops RWEL
        {2'd0, 1'b0, 8'h00, 1'b1, 8'h02},  // R4
        {2'd1, 1'b0, 8'h00, 1'b0, 8'h00},  // R4 WEL clear
        {2'd0, 1'b0, 8'h46, 1'b0, 8'h00},  // R3
        {2'd0, 1'b0, 8'h02, 1'b1, 8'h00},
        {2'd1, 1'b0, 8'h00, 1'b0, 8'h02},
        {2'd0, 1'b0, 8'h46, 1'b0, 8'h02}   // R7 refused without RWEL
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwr_cyc = 1'b0;
    logic       wr_stb = 1'b0;
    logic [7:0] wr_byte = '0;
    logic       stop_stb = 1'b0;
    logic       wp = 1'b0;
    logic [7:0] cfg_q;
    logic       data_ack;
    logic       nv_busy;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    wdcfg_guard #(.NV_CYCLES(NVC)) u_wdcfg_guard (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwr_cyc  (pwr_cyc),
        .wr_stb   (wr_stb),
        .wr_byte  (wr_byte),
        .stop_stb (stop_stb),
        .wp       (wp),
        .cfg_q    (cfg_q),
        .data_ack (data_ack),
        .nv_busy  (nv_busy)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic put_byte(input logic [7:0] b, input logic p, input logic exp_ack, input string tag);
        @(negedge clk);
        wr_stb = 1'b1; wr_byte = b; wp = p;
        #1;
        check({tag, " ack"}, {7'd0, data_ack}, {7'd0, exp_ack});
        @(negedge clk);
        wr_stb = 1'b0; wp = 1'b0;
    endtask

    task automatic put_stop();
        @(negedge clk);
        stop_stb = 1'b1;
        @(negedge clk);
        stop_stb = 1'b0;
    endtask

    task automatic drain();
        for (int i = 0; i < 100 && nv_busy; i++) @(negedge clk);
    endtask

    initial begin
        int busy_len;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset cfg", cfg_q, 8'h60);
        check("R1 reset busy", {7'd0, nv_busy}, 8'h00);
        check("R1 reset ack", {7'd0, data_ack}, 8'h00);

        for (int r = 0; r < NV; r++) begin
            if (VEC[r][19:18] == 2'd0) begin
                put_byte(VEC[r][16:9], VEC[r][17], VEC[r][8], $sformatf("row%0d", r));
            end else begin
                put_stop();
            end
            check($sformatf("row%0d cfg", r), cfg_q, VEC[r][7:0]);
            drain();
        end

        // R11: second byte before stop cancels the first
        put_byte(8'h06, 1'b0, 1'b1, "R11 first");
        put_byte(8'h06, 1'b0, 1'b0, "R11 second");
        put_stop();
        check("R11 cfg", cfg_q, 8'h02);

        // R12: bare stop
        put_stop();
        check("R12 cfg", cfg_q, 8'h02);

        // R6: busy window length
        put_byte(8'h06, 1'b0, 1'b1, "R6 arm");
        put_stop();
        put_byte(8'h42, 1'b0, 1'b1, "R6 commit");
        put_stop();
        check("R6 cfg", cfg_q, 8'h42);
        busy_len = 0;
        for (int i = 0; i < 100 && nv_busy; i++) begin
            busy_len++;
            @(negedge clk);
        end
        check("R6 busy length", 8'(busy_len), 8'(NVC));

        // R9: refused while busy
        put_byte(8'h06, 1'b0, 1'b1, "R9 arm");
        put_stop();
        put_byte(8'h22, 1'b0, 1'b1, "R9 commit");
        put_stop();
        put_byte(8'h00, 1'b0, 1'b0, "R9 busy byte");
        put_stop();
        drain();
        check("R9 cfg", cfg_q, 8'h22);

        // R2: power cycle keeps period
        @(negedge clk); pwr_cyc = 1'b1;
        @(negedge clk); pwr_cyc = 1'b0;
        check("R2 cfg", cfg_q, 8'h20);

        // R1: chip reset restores factory period
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check("R1 re-reset cfg", cfg_q, 8'h60);
        check("R1 re-reset busy", {7'd0, nv_busy}, 8'h00);

        finished = 1'b1;
    end

    initial begin
        for (int c = 0; c < 20000 && !finished; c++) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule